// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is a single-port memory with one address bus, one write data bus and a registered read data output. Every operation takes effect on the active edge of one clock, and only while the port enable is active. Parameters fix the data width, the depth, the fill value that every location holds at start-up, and whether the block acts as a writable RAM or as a ROM.

A static write-mode parameter decides what the output shows on a write cycle: the new data, the data that was in the location before, or the last read value left unchanged. A synchronous output-initialisation input loads a parameterised constant into the final output register and leaves the memory alone. An optional register stage on the address, data and write-enable inputs, and an optional extra register on the output, each add one cycle of read latency. The polarity of the enable, write-enable and initialisation inputs and the active clock edge can all be set by parameter. A small handshake reports that the port can accept an access and marks, after the configured latency, the output cycles that carry the data of a flagged access.

Top module: `cfg_sp_ram`

## Requirements
- R1: While rst_ni is low, dout_o equals SINIT_VAL and rdy_o is low.
- R2: A read returns the last data written to that location. A location that has never been written returns FILL_VAL, which defaults to zero.
- R3: Read data reaches dout_o after LAT = 1 + IN_REG + OUT_REG enabled active edges, so after the first, second or third such edge.
- R4: In write-first mode (MODE = WM_WRITE_FIRST, the default), a write cycle carries the written data to dout_o.
- R5: In read-first mode (MODE = WM_READ_FIRST), a write cycle carries the location's previous contents to dout_o.
- R6: In no-change mode (MODE = WM_NO_CHANGE), a write cycle leaves dout_o at its last value.
- R7: While the enable is inactive, no write takes place, dout_o and rdy_o hold, and the initialisation input has no effect.
- R8: An enabled edge with the initialisation input active loads SINIT_VAL into the final output register. This takes priority over read data. Memory is not changed, and a write in the same cycle still completes.
- R9: EN_LOW, WE_LOW and SINIT_LOW each make their input active low (1 = low). FALL_EDGE = 1 moves all operations to the falling clock edge.
- R10: rfd_o is high exactly while the enable input is in its active state.
- R11: rdy_o repeats nd_i delayed by LAT enabled edges. nd_i has no effect on memory or on dout_o.
- R12: With IS_ROM = 1, we_i and din_i are ignored and the contents stay at FILL_VAL.
- R13: An address at or above DEPTH performs no write. It loads FILL_VAL as read data, and in write-first mode also as write data. A no-change write holds dout_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; active edge set by FALL_EDGE |
| rst_ni | input | 1 | Asynchronous reset of the pipeline registers, active low |
| en_i | input | 1 | Port enable, polarity set by EN_LOW |
| we_i | input | 1 | Write enable, polarity set by WE_LOW; ignored when IS_ROM |
| sinit_i | input | 1 | Synchronous output initialisation, polarity set by SINIT_LOW |
| addr_i | input | AW | Word address, AW = ceil(log2(DEPTH)) |
| din_i | input | WIDTH | Write data; ignored when IS_ROM |
| nd_i | input | 1 | Marks the current access as new and valid |
| dout_o | output | WIDTH | Registered read data |
| rfd_o | output | 1 | Port ready for a new access |
| rdy_o | output | 1 | dout_o carries the data of a flagged access |

## Verification
The bench drives one stimulus stream into four instances at DEPTH 48 and WIDTH 16. The first is write-first with no extra registers and the default rising edge and polarities. The second is read-first with both register stages, all controls active low and the falling edge. The third is no-change with only the output register and the default fill and initialisation values. The fourth is a ROM with only the input register. Between them these four cover every latency from one to three, each write mode, both clock edges, both polarities, the zero defaults and the ROM case. Because DEPTH is not a power of two, addresses 48 to 63 test the out-of-range path.

// File: rtl/spram_pkg.sv
`timescale 1ns/1ps
package spram_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/spram_in_stage.sv
`timescale 1ns/1ps
module spram_in_stage #(
  parameter int AW     = 6,
  parameter int WIDTH  = 16,
  parameter bit IN_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             we_i,
  output logic [AW-1:0]    addr_o,
  output logic [WIDTH-1:0] din_o,
  output logic             we_o
);
  generate
    if (IN_REG) begin : g_reg
      logic [AW-1:0]    addr_q;
      logic [WIDTH-1:0] din_q;
      logic             we_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q <= '0;
          din_q  <= '0;
          we_q   <= 1'b0;
        end else if (en_i) begin
          addr_q <= addr_i;
          din_q  <= din_i;
          we_q   <= we_i;
        end
      end
      assign addr_o = addr_q;
      assign din_o  = din_q;
      assign we_o   = we_q;
    end else begin : g_thru
      logic unused_thru;
      assign unused_thru = &{1'b0, clk_i, rst_ni, en_i};
      assign addr_o = addr_i;
      assign din_o  = din_i;
      assign we_o   = we_i;
    end
  endgenerate
endmodule

// File: rtl/spram_array.sv
`timescale 1ns/1ps
module spram_array
  import spram_pkg::*;
#(
  parameter int               AW        = 6,
  parameter int               WIDTH     = 16,
  parameter int               DEPTH     = 48,
  parameter wmode_e           MODE      = WM_WRITE_FIRST,
  parameter logic [WIDTH-1:0] FILL_VAL  = '0,
  parameter logic [WIDTH-1:0] SINIT_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             sinit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] rd_q_o
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH] = '{default: FILL_VAL};
  logic             hit;
  logic [AW-1:0]    addr_safe;
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] wr_view;
  logic [WIDTH-1:0] rd_q;

  assign hit       = ({1'b0, addr_i} < DEPTH_W);
  assign addr_safe = hit ? addr_i : '0;
  assign rd_word   = hit ? mem[addr_safe] : FILL_VAL;
  assign wr_view   = hit ? din_i : FILL_VAL;

  // out-of-range writes are dropped; sinit never blocks a write
  always_ff @(posedge clk_i) begin
    if (en_i && we_i && hit) mem[addr_safe] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= SINIT_VAL;
    end else if (en_i) begin
      if (sinit_i) begin
        rd_q <= SINIT_VAL;
      end else if (we_i) begin
        case (MODE)
          WM_WRITE_FIRST: rd_q <= wr_view;
          WM_READ_FIRST:  rd_q <= rd_word;
          default:        rd_q <= rd_q;
        endcase
      end else begin
        rd_q <= rd_word;
      end
    end
  end

  assign rd_q_o = rd_q;
endmodule

// File: rtl/spram_out_stage.sv
`timescale 1ns/1ps
module spram_out_stage #(
  parameter int               WIDTH     = 16,
  parameter bit               OUT_REG   = 1'b0,
  parameter logic [WIDTH-1:0] SINIT_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sinit_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= SINIT_VAL;
        else if (en_i)    q <= sinit_i ? SINIT_VAL : d_i;
      end
      assign q_o = q;
    end else begin : g_thru
      logic unused_thru;
      assign unused_thru = &{1'b0, clk_i, rst_ni, en_i, sinit_i};
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/spram_hs.sv
`timescale 1ns/1ps
module spram_hs #(
  parameter int LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic nd_i,
  output logic rdy_o
);
  logic [LAT-1:0] pipe;

  // advances only on enabled edges so rdy stays aligned with dout
  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pipe <= '0;
        else if (en_i) pipe <= nd_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pipe <= '0;
        else if (en_i) pipe <= {pipe[LAT-2:0], nd_i};
      end
    end
  endgenerate

  assign rdy_o = pipe[LAT-1];
endmodule

// File: rtl/cfg_sp_ram.sv
`timescale 1ns/1ps
module cfg_sp_ram
  import spram_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter int               DEPTH     = 48,
  parameter wmode_e           MODE      = WM_WRITE_FIRST,
  parameter bit               IS_ROM    = 1'b0,
  parameter bit               IN_REG    = 1'b0,
  parameter bit               OUT_REG   = 1'b0,
  parameter bit               EN_LOW    = 1'b0,
  parameter bit               WE_LOW    = 1'b0,
  parameter bit               SINIT_LOW = 1'b0,
  parameter bit               FALL_EDGE = 1'b0,
  parameter logic [WIDTH-1:0] FILL_VAL  = '0,
  parameter logic [WIDTH-1:0] SINIT_VAL = '0,
  localparam int              AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             sinit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             nd_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             rfd_o,
  output logic             rdy_o
);
  localparam int LAT = 1 + int'(IN_REG) + int'(OUT_REG);

  logic             clk_int;
  logic             en_act;
  logic             we_act;
  logic             sinit_act;
  logic             sinit_arr;
  logic [AW-1:0]    a_addr;
  logic [WIDTH-1:0] a_din;
  logic             a_we;
  logic [WIDTH-1:0] arr_q;

  assign clk_int   = clk_i ^ FALL_EDGE;
  assign en_act    = en_i ^ EN_LOW;
  assign we_act    = IS_ROM ? 1'b0 : (we_i ^ WE_LOW);
  assign sinit_act = sinit_i ^ SINIT_LOW;
  // sinit always lands on the last register of the read path
  assign sinit_arr = OUT_REG ? 1'b0 : sinit_act;
  assign rfd_o     = en_act;

  spram_in_stage #(.AW(AW), .WIDTH(WIDTH), .IN_REG(IN_REG)) u_in (
    .clk_i  (clk_int),
    .rst_ni (rst_ni),
    .en_i   (en_act),
    .addr_i (addr_i),
    .din_i  (din_i),
    .we_i   (we_act),
    .addr_o (a_addr),
    .din_o  (a_din),
    .we_o   (a_we)
  );

  spram_array #(
    .AW(AW), .WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE),
    .FILL_VAL(FILL_VAL), .SINIT_VAL(SINIT_VAL)
  ) u_arr (
    .clk_i   (clk_int),
    .rst_ni  (rst_ni),
    .en_i    (en_act),
    .we_i    (a_we),
    .sinit_i (sinit_arr),
    .addr_i  (a_addr),
    .din_i   (a_din),
    .rd_q_o  (arr_q)
  );

  spram_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG), .SINIT_VAL(SINIT_VAL)) u_out (
    .clk_i   (clk_int),
    .rst_ni  (rst_ni),
    .en_i    (en_act),
    .sinit_i (sinit_act),
    .d_i     (arr_q),
    .q_o     (dout_o)
  );

  spram_hs #(.LAT(LAT)) u_hs (
    .clk_i  (clk_int),
    .rst_ni (rst_ni),
    .en_i   (en_act),
    .nd_i   (nd_i),
    .rdy_o  (rdy_o)
  );
endmodule

// File: rtl/cfg_sp_ram_chk.sv
`timescale 1ns/1ps
module cfg_sp_ram_chk
  import spram_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter int               DEPTH     = 48,
  parameter int               AW        = 6,
  parameter wmode_e           MODE      = WM_WRITE_FIRST,
  parameter bit               IN_REG    = 1'b0,
  parameter bit               OUT_REG   = 1'b0,
  parameter logic [WIDTH-1:0] SINIT_VAL = '0
) (
  input logic             clk_int,
  input logic             rst_ni,
  input logic             en_act,
  input logic             sinit_act,
  input logic             a_we,
  input logic [AW-1:0]    a_addr,
  input logic [WIDTH-1:0] a_din,
  input logic             nd_i,
  input logic [WIDTH-1:0] dout_o,
  input logic             rdy_o
);
  localparam int LAT = 1 + int'(IN_REG) + int'(OUT_REG);

  logic unused_chk;
  assign unused_chk = &{1'b0, a_addr, a_din, a_we, nd_i};

  AST_IDLE_HOLDS_DOUT: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !en_act |=> $stable(dout_o));  // R7
  AST_IDLE_HOLDS_RDY: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !en_act |=> $stable(rdy_o));  // R7
  AST_SINIT_LOADS: assert property (@(posedge clk_int) disable iff (!rst_ni)
    en_act && sinit_act |=> dout_o == SINIT_VAL);  // R8

  generate
    if (LAT == 1) begin : g_lat1
      AST_RDY_FOLLOWS_ND: assert property (@(posedge clk_int) disable iff (!rst_ni)
        en_act |=> rdy_o == $past(nd_i));  // R11
    end
    if (!OUT_REG && MODE == WM_NO_CHANGE) begin : g_nc
      AST_NC_WRITE_HOLDS: assert property (@(posedge clk_int) disable iff (!rst_ni)
        en_act && a_we && !sinit_act |=> $stable(dout_o));  // R6
    end
    if (!OUT_REG && MODE == WM_WRITE_FIRST) begin : g_wf
      AST_WF_SHOWS_DIN: assert property (@(posedge clk_int) disable iff (!rst_ni)
        en_act && a_we && !sinit_act && (int'(a_addr) < DEPTH) |=> dout_o == $past(a_din));  // R4
    end
  endgenerate
endmodule

bind cfg_sp_ram cfg_sp_ram_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .MODE(MODE),
  .IN_REG(IN_REG), .OUT_REG(OUT_REG), .SINIT_VAL(SINIT_VAL)
) u_chk (.*);

// File: tb/spram_sb.sv
`timescale 1ns/1ps
module spram_sb
  import spram_pkg::*;
#(
  parameter string            NAME      = "dut",
  parameter int               WIDTH     = 16,
  parameter int               DEPTH     = 48,
  parameter int               AW        = 6,
  parameter wmode_e           MODE      = WM_WRITE_FIRST,
  parameter bit               IS_ROM    = 1'b0,
  parameter bit               IN_REG    = 1'b0,
  parameter bit               OUT_REG   = 1'b0,
  parameter logic [WIDTH-1:0] FILL_VAL  = '0,
  parameter logic [WIDTH-1:0] SINIT_VAL = '0
) (
  input logic             clk_i,
  input logic [WIDTH-1:0] dout_i,
  input logic             rdy_i,
  input logic             rfd_i
);
  localparam int LAT = 1 + int'(IN_REG) + int'(OUT_REG);

  typedef struct {
    logic [WIDTH-1:0] dout;
    logic             rdy;
    string            req;
  } item_t;

  item_t            q[$];
  int               n_chk = 0;
  int               n_fail = 0;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    ia = '0;
  logic [WIDTH-1:0] id = '0;
  bit               iw = 1'b0;
  logic [WIDTH-1:0] lat = SINIT_VAL;
  logic [WIDTH-1:0] oq = SINIT_VAL;
  logic [2:0]       ndp = '0;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = FILL_VAL;

  // expected post-edge state for one cycle of logical stimulus
  task automatic apply(input bit en, input bit we, input bit si, input logic [AW-1:0] addr,
                       input logic [WIDTH-1:0] din, input bit nd, input string req);
    logic [AW-1:0]    a;
    logic [WIDTH-1:0] d, rd, lat_n;
    bit               w, hit;
    item_t            e;
    if (en) begin
      if (IN_REG) begin
        a = ia; d = id; w = iw;
        ia = addr; id = din; iw = we;
      end else begin
        a = addr; d = din; w = we;
      end
      if (IS_ROM) w = 1'b0;
      hit = int'(a) < DEPTH;
      rd = FILL_VAL;
      if (hit) rd = mem[int'(a)];
      lat_n = lat;
      if (!OUT_REG && si)          lat_n = SINIT_VAL;
      else if (!w)                 lat_n = rd;
      else if (MODE == WM_WRITE_FIRST) lat_n = hit ? d : FILL_VAL;
      else if (MODE == WM_READ_FIRST)  lat_n = rd;
      if (w && hit) mem[int'(a)] = d;
      if (OUT_REG) oq = si ? SINIT_VAL : lat;
      lat = lat_n;
      ndp = {ndp[1:0], nd};
    end
    e.dout = OUT_REG ? oq : lat;
    e.rdy  = ndp[LAT-1];
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic check_now(input logic [WIDTH-1:0] exp_d, input bit exp_r, input string req);
    n_chk++;
    if (dout_i !== exp_d || rdy_i !== exp_r) begin
      n_fail++;
      $display("FAIL %s %s: dout=%h rdy=%b expected dout=%h rdy=%b", req, NAME, dout_i, rdy_i, exp_d, exp_r);
    end
  endtask

  task automatic check_rfd(input bit exp_r, input string req);
    n_chk++;
    if (rfd_i !== exp_r) begin
      n_fail++;
      $display("FAIL %s %s: rfd=%b expected %b", req, NAME, rfd_i, exp_r);
    end
  endtask

  always begin
    item_t e;
    @(posedge clk_i);
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check_now(e.dout, e.rdy, e.req);
    end
  end
endmodule

// File: tb/cfg_sp_ram_bench.sv
`timescale 1ns/1ps
module cfg_sp_ram_bench;
  import spram_pkg::*;
  localparam int W = 16;
  localparam int D = 48;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          en_h = 1'b0, we_h = 1'b0, si_h = 1'b0, nd_s = 1'b0;
  logic [AW-1:0] addr_s = '0;
  logic [W-1:0]  din_s = '0;
  logic [W-1:0]  d_wf, d_rf, d_nc, d_rom;
  logic          r_wf, r_rf, r_nc, r_rom;
  logic          f_wf, f_rf, f_nc, f_rom;
  int            b_chk = 0, b_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  // A: write-first, latency 1, defaults
  cfg_sp_ram #(.WIDTH(W), .DEPTH(D), .FILL_VAL(16'hA5A5), .SINIT_VAL(16'h5A5A)) u_cfg_sp_ram (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_h), .we_i(we_h), .sinit_i(si_h), .addr_i(addr_s),
    .din_i(din_s), .nd_i(nd_s), .dout_o(d_wf), .rfd_o(f_wf), .rdy_o(r_wf));
  // B: read-first, latency 3, active-low controls, falling edge (R9)
  cfg_sp_ram #(.WIDTH(W), .DEPTH(D), .MODE(WM_READ_FIRST), .IN_REG(1'b1), .OUT_REG(1'b1),
    .EN_LOW(1'b1), .WE_LOW(1'b1), .SINIT_LOW(1'b1), .FALL_EDGE(1'b1),
    .FILL_VAL(16'hA5A5), .SINIT_VAL(16'h0123)) u_cfg_sp_ram_rf (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(~en_h), .we_i(~we_h), .sinit_i(~si_h), .addr_i(addr_s),
    .din_i(din_s), .nd_i(nd_s), .dout_o(d_rf), .rfd_o(f_rf), .rdy_o(r_rf));
  // C: no-change, output register, default fill and sinit values
  cfg_sp_ram #(.WIDTH(W), .DEPTH(D), .MODE(WM_NO_CHANGE), .OUT_REG(1'b1)) u_cfg_sp_ram_nc (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_h), .we_i(we_h), .sinit_i(si_h), .addr_i(addr_s),
    .din_i(din_s), .nd_i(nd_s), .dout_o(d_nc), .rfd_o(f_nc), .rdy_o(r_nc));
  // D: ROM with input register
  cfg_sp_ram #(.WIDTH(W), .DEPTH(D), .IS_ROM(1'b1), .IN_REG(1'b1),
    .FILL_VAL(16'h0F0F), .SINIT_VAL(16'hFFFF)) u_cfg_sp_ram_rom (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_h), .we_i(we_h), .sinit_i(si_h), .addr_i(addr_s),
    .din_i(din_s), .nd_i(nd_s), .dout_o(d_rom), .rfd_o(f_rom), .rdy_o(r_rom));

  spram_sb #(.NAME("wf_lat1"), .WIDTH(W), .DEPTH(D), .AW(AW),
    .FILL_VAL(16'hA5A5), .SINIT_VAL(16'h5A5A)) u_sb_wf (.clk_i(clk), .dout_i(d_wf), .rdy_i(r_wf), .rfd_i(f_wf));
  spram_sb #(.NAME("rf_lat3_lowpol_fall_R9"), .WIDTH(W), .DEPTH(D), .AW(AW), .MODE(WM_READ_FIRST),
    .IN_REG(1'b1), .OUT_REG(1'b1), .FILL_VAL(16'hA5A5), .SINIT_VAL(16'h0123))
    u_sb_rf (.clk_i(clk), .dout_i(d_rf), .rdy_i(r_rf), .rfd_i(f_rf));
  spram_sb #(.NAME("nc_lat2"), .WIDTH(W), .DEPTH(D), .AW(AW), .MODE(WM_NO_CHANGE), .OUT_REG(1'b1))
    u_sb_nc (.clk_i(clk), .dout_i(d_nc), .rdy_i(r_nc), .rfd_i(f_nc));
  spram_sb #(.NAME("rom_lat2_R12"), .WIDTH(W), .DEPTH(D), .AW(AW), .IS_ROM(1'b1), .IN_REG(1'b1),
    .FILL_VAL(16'h0F0F), .SINIT_VAL(16'hFFFF))
    u_sb_rom (.clk_i(clk), .dout_i(d_rom), .rdy_i(r_rom), .rfd_i(f_rom));

  task automatic step(input bit en, input bit we, input bit si, input int addr,
                      input logic [W-1:0] din, input bit nd, input string req);
    @(posedge clk);
    #3;
    en_h = en; we_h = we; si_h = si; nd_s = nd;
    addr_s = addr[AW-1:0]; din_s = din;
    u_sb_wf.apply(en, we, si, addr[AW-1:0], din, nd, req);
    u_sb_rf.apply(en, we, si, addr[AW-1:0], din, nd, req);
    u_sb_nc.apply(en, we, si, addr[AW-1:0], din, nd, req);
    u_sb_rom.apply(en, we, si, addr[AW-1:0], din, nd, req);
    #1;
    u_sb_wf.check_rfd(en, "R10");
    u_sb_rf.check_rfd(en, "R10");
    u_sb_nc.check_rfd(en, "R10");
    u_sb_rom.check_rfd(en, "R10");
  endtask

  task automatic report();
    int t, f;
    t = b_chk + u_sb_wf.n_chk + u_sb_rf.n_chk + u_sb_nc.n_chk + u_sb_rom.n_chk;
    f = b_fail + u_sb_wf.n_fail + u_sb_rf.n_fail + u_sb_nc.n_fail + u_sb_rom.n_fail;
    $display("[TB] %0d tests run, %0d failed", t, f);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      b_chk++;
      b_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    u_sb_wf.check_now(16'h5A5A, 1'b0, "R1");
    u_sb_rf.check_now(16'h0123, 1'b0, "R1");
    u_sb_nc.check_now(16'h0000, 1'b0, "R1");
    u_sb_rom.check_now(16'hFFFF, 1'b0, "R1");
    @(posedge clk);
    #3 rst_ni = 1'b1;

    // R2: unwritten locations give the fill value
    for (int i = 0; i < 4; i++) step(1, 0, 0, 10 + i, 16'h0, 0, "R2");
    // R4/R5/R6/R12: first writes
    for (int i = 0; i < 8; i++) step(1, 1, 0, i, 16'h1000 + 16'(i * 3), 1, "R4_R5_R6");
    // R2/R3/R11: read back with alternating nd
    for (int i = 0; i < 8; i++) step(1, 0, 0, i, 16'hFFFF, i[0], "R3_R11");
    // R5: overwrite shows old contents in read-first
    step(1, 1, 0, 3, 16'hBEEF, 1, "R5");
    step(1, 1, 0, 3, 16'hCAFE, 0, "R5");
    step(1, 0, 0, 3, 16'h0, 1, "R2");
    step(1, 0, 0, 4, 16'h0, 0, "R2");
    // R7: disabled cycles with write, sinit and nd asserted
    for (int i = 0; i < 4; i++) step(0, 1, 1, 5, 16'hDEAD, 1, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 5, 16'h0, 0, "R7");
    // R8: sinit with read, sinit with write, then read back the write
    step(1, 0, 1, 2, 16'h0, 1, "R8");
    step(1, 0, 0, 2, 16'h0, 0, "R8");
    step(1, 1, 1, 6, 16'h7777, 0, "R8");
    step(1, 0, 0, 6, 16'h0, 1, "R8");
    step(1, 0, 0, 6, 16'h0, 0, "R8");
    step(1, 0, 0, 6, 16'h0, 0, "R8");
    // R13: out-of-range write and reads; address 50 aliases 2 in low bits
    step(1, 1, 0, 50, 16'h1234, 1, "R13");
    step(1, 0, 0, 50, 16'h0, 0, "R13");
    step(1, 0, 0, 2, 16'h0, 1, "R13");
    step(1, 0, 0, 48, 16'h0, 0, "R13");
    step(1, 0, 0, 63, 16'h0, 0, "R13");
    step(1, 0, 0, 47, 16'h0, 0, "R13");
    // R3/R11: dense mixed traffic with enable gaps
    for (int i = 0; i < 40; i++)
      step((i % 7) != 3, i[1], (i % 11) == 5, i % 12, 16'h4000 + 16'(i * 17), i[0] ^ i[2], "R3_R11");
    for (int i = 0; i < 12; i++) step(1, 0, 0, i, 16'h0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 16'h0, 0, "R3");
    @(posedge clk);
    #4;
    done = 1'b1;
    report();
  end
endmodule